// File: doc/BRIEF.md
# I2C Slave Event Servicer with Loop-Back Byte Store

This block sits on the host side of an I2C slave port. It takes over the work that a service routine would otherwise do on every port event. When the port raises its event flag, the block samples the port's status word and masks it down to four bits. It then matches the result against five legal event patterns and carries out the action that belongs to the matched pattern.

A write transaction from the bus master empties a 32-entry byte store. The data bytes that follow are placed into the store in order. A later read transaction returns those bytes in the same order, through a send handshake on the port's transmit buffer. That handshake waits for the buffer to drain, clears and retries write collisions, and finally releases the held serial clock. A status word that matches no legal pattern traps the block until reset.

Top module: `i2c_evt_ctrl`

## Requirements
- R1: Only four status bits are decoded: bit 0 (buffer full), bit 2 (read/write), bit 3 (start seen) and bit 5 (data/address). All other status bits have no effect on which event is recognised.
- R2: Address-of-write event (start=1, data/address=0, read/write=0, full=1): the block issues exactly one dummy read strobe, sets every store entry to zero and resets the store index to 0.
- R3: Write-data event (start=1, data/address=1, read/write=0, full=1): the block issues one read strobe, stores `rxData` at the index and advances the index. When the index reaches 32 it returns to 0, so the 33rd byte overwrites entry 0.
- R4: Address-of-read event (start=1, data/address=0, read/write=1, full=0): the index is reset, entry 0 is sent and the index becomes 1.
- R5: Read-data event (start=1, data/address=1, read/write=1, full=0): if the index equals 32 it first returns to 0. Then the entry at the index is sent and the index advances.
- R6: Master-NACK event (start=1, data/address=1, read/write=0, full=0): no read, write, collision-clear or release strobe is issued; only the event is acknowledged.
- R7: Any other masked status value raises `errTrap`. It stays high, and no further event is acknowledged or serviced, until reset.
- R8: Sending a byte waits while status bit 0 is 1. It then pulses `wcolClr`, then pulses `bufWrStb` with the byte on `txData`, and repeats the clear and the write while `wcol` is reported after a write. When no collision is reported it gives exactly one `relStb` pulse.
- R9: One event is handled at a time. `evtAck` pulses once, after the action finishes. Flag rising edges that arrive while busy are ignored, and a flag held high is not serviced twice.
- R10: `relStb` stays low throughout the zeroing of the store, so the serial clock remains held until a send completes.
- R11: After reset all strobe outputs and `errTrap` are low, and `addrOut` presents the slave address parameter (default 0x02).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtFlag | input | 1 | Port event flag; a rising edge requests service |
| evtAck | output | 1 | One-cycle acknowledge when the event's action is complete |
| status | input | 8 | Port status word |
| rxData | input | 8 | Byte held in the port's receive buffer |
| bufRdStb | output | 1 | Read strobe for the port buffer |
| txData | output | 8 | Byte offered to the port's transmit buffer |
| bufWrStb | output | 1 | Write strobe for the port buffer |
| wcol | input | 1 | Write-collision flag from the port |
| wcolClr | output | 1 | Pulse that clears the collision flag |
| relStb | output | 1 | Pulse that sets the port's clock-release bit |
| errTrap | output | 1 | Sticky illegal-status trap |
| addrOut | output | 8 | Slave address value for the port's match register |

## Verification
The hardest behaviour to reach is the read-data event that finds the index at 32. Getting there takes a store emptied by an address-of-write event, 33 writes that wrap the index over entry 0, an address-of-read event, and then 31 read-data events before the 32nd one wraps. The stimulus plays exactly that sequence, and a scoreboard compares every released byte against an independent model of the store. A port model injects a chosen number of write collisions and raises the buffer-full bit partway through a send, which exercises the retry loop and the drain wait. A second flag edge is delivered during the 32-cycle zeroing to show that it is dropped.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  localparam int BIT_FULL  = 0;
  localparam int BIT_RDWR  = 2;
  localparam int BIT_START = 3;
  localparam int BIT_DATA  = 5;

  localparam logic [7:0] STAT_MASK = 8'(1 << BIT_FULL) | 8'(1 << BIT_RDWR) |
                                     8'(1 << BIT_START) | 8'(1 << BIT_DATA);

  typedef enum logic [2:0] {
    EV_WADDR, EV_WDATA, EV_RADDR, EV_RDATA, EV_NACK, EV_BAD
  } evtKind_t;

  typedef struct packed {
    logic zeroStep;
    logic idxClr;
    logic storeRx;
    logic loadTx;
  } dpStb_t;

  function automatic evtKind_t classify(input logic [7:0] st);
    logic [3:0] key;
    key = {st[BIT_START], st[BIT_DATA], st[BIT_RDWR], st[BIT_FULL]};
    case (key)
      4'b1001: classify = EV_WADDR;
      4'b1101: classify = EV_WDATA;
      4'b1010: classify = EV_RADDR;
      4'b1110: classify = EV_RDATA;
      4'b1100: classify = EV_NACK;
      default: classify = EV_BAD;
    endcase
  endfunction

endpackage

// File: rtl/i2c_evt_buf.sv
module i2c_evt_buf
  import i2c_evt_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStb_t        stb,
  input  logic [DW-1:0] rxData,
  output logic [DW-1:0] txData,
  output logic          zeroLast
);

  localparam int IW = $clog2(DEPTH + 1);
  localparam int ZW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0] idx;
  logic [IW-1:0] sel;
  logic [IW-1:0] selNext;
  logic [ZW-1:0] zeroPtr;
  logic [DW-1:0] entry [DEPTH];

  // An index parked at DEPTH (after a full read sweep) folds back to 0.
  assign sel      = (idx == IW'(DEPTH)) ? '0 : idx;
  assign selNext  = sel + 1'b1;
  assign zeroLast = (zeroPtr == ZW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      zeroPtr <= '0;
      txData  <= '0;
    end else begin
      if (stb.zeroStep) zeroPtr <= zeroLast ? '0 : zeroPtr + 1'b1;
      if (stb.idxClr) begin
        idx <= '0;
      end else if (stb.storeRx) begin
        idx <= (selNext == IW'(DEPTH)) ? '0 : selNext;
      end else if (stb.loadTx) begin
        idx    <= selNext;
        txData <= entry[sel[ZW-1:0]];
      end
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entry[gi] <= '0;
      end else if (stb.zeroStep && zeroPtr == ZW'(gi)) begin
        entry[gi] <= '0;
      end else if (stb.storeRx && sel == IW'(gi)) begin
        entry[gi] <= rxData;
      end
    end
  end

  a_r3_index_bound: assert property (@(posedge clk) disable iff (!rstN)
    idx <= IW'(DEPTH));

  a_r3_store_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (stb.storeRx && sel == IW'(DEPTH - 1)) |=> idx == '0);

  a_r4_first_read_index: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.idxClr) && stb.loadTx) |=> idx == IW'(1));

endmodule

// File: rtl/i2c_evt_fsm.sv
module i2c_evt_fsm
  import i2c_evt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtFlag,
  input  logic [7:0] status,
  input  logic       wcol,
  input  logic       zeroLast,
  output dpStb_t     stb,
  output logic       evtAck,
  output logic       bufRdStb,
  output logic       bufWrStb,
  output logic       wcolClr,
  output logic       relStb,
  output logic       errTrap
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_DUMMY, ST_ZERO, ST_STORE, ST_IDXCLR, ST_LOAD, ST_WAITBF,
    ST_CLRW, ST_WRITE, ST_CHECK, ST_REL, ST_ACK, ST_TRAP
  } st_t;

  st_t  state, nxt;
  logic evtPrev;
  logic evtRise;

  assign evtRise = evtFlag && !evtPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      evtPrev <= 1'b0;
    end else begin
      state   <= nxt;
      evtPrev <= evtFlag;
    end
  end

  always_comb begin
    nxt      = state;
    stb      = '0;
    evtAck   = 1'b0;
    bufRdStb = 1'b0;
    bufWrStb = 1'b0;
    wcolClr  = 1'b0;
    relStb   = 1'b0;
    errTrap  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (evtRise) begin
          case (classify(status))
            EV_WADDR: nxt = ST_DUMMY;
            EV_WDATA: nxt = ST_STORE;
            EV_RADDR: nxt = ST_IDXCLR;
            EV_RDATA: nxt = ST_LOAD;
            EV_NACK:  nxt = ST_ACK;
            default:  nxt = ST_TRAP;
          endcase
        end
      end
      ST_DUMMY: begin
        bufRdStb   = 1'b1;
        stb.idxClr = 1'b1;
        nxt        = ST_ZERO;
      end
      ST_ZERO: begin
        stb.zeroStep = 1'b1;
        if (zeroLast) nxt = ST_ACK;
      end
      ST_STORE: begin
        bufRdStb    = 1'b1;
        stb.storeRx = 1'b1;
        nxt         = ST_ACK;
      end
      ST_IDXCLR: begin
        stb.idxClr = 1'b1;
        nxt        = ST_LOAD;
      end
      ST_LOAD: begin
        stb.loadTx = 1'b1;
        nxt        = ST_WAITBF;
      end
      ST_WAITBF: if (!status[BIT_FULL]) nxt = ST_CLRW;
      ST_CLRW: begin
        wcolClr = 1'b1;
        nxt     = ST_WRITE;
      end
      ST_WRITE: begin
        bufWrStb = 1'b1;
        nxt      = ST_CHECK;
      end
      ST_CHECK: nxt = wcol ? ST_CLRW : ST_REL;
      ST_REL: begin
        relStb = 1'b1;
        nxt    = ST_ACK;
      end
      ST_ACK: begin
        evtAck = 1'b1;
        nxt    = ST_IDLE;
      end
      ST_TRAP: errTrap = 1'b1;
      default: nxt = ST_IDLE;
    endcase
  end

  a_r7_trap_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errTrap |=> errTrap);

  a_r7_trap_silent: assert property (@(posedge clk) disable iff (!rstN)
    errTrap |-> !(evtAck || bufRdStb || bufWrStb || relStb));

  a_r8_write_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    bufWrStb |-> $past(wcolClr));

  a_r8_release_clean: assert property (@(posedge clk) disable iff (!rstN)
    relStb |-> !$past(wcol));

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    evtAck |=> !evtAck);

endmodule

// File: rtl/i2c_evt_ctrl.sv
module i2c_evt_ctrl
  import i2c_evt_pkg::*;
#(
  parameter int         DEPTH     = 32,
  parameter logic [7:0] SLAVE_ADR = 8'h02
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evtFlag,
  output logic       evtAck,
  input  logic [7:0] status,
  input  logic [7:0] rxData,
  output logic       bufRdStb,
  output logic [7:0] txData,
  output logic       bufWrStb,
  input  logic       wcol,
  output logic       wcolClr,
  output logic       relStb,
  output logic       errTrap,
  output logic [7:0] addrOut
);

  dpStb_t stb;
  logic   zeroLast;

  assign addrOut = SLAVE_ADR;

  i2c_evt_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .evtFlag  (evtFlag),
    .status   (status),
    .wcol     (wcol),
    .zeroLast (zeroLast),
    .stb      (stb),
    .evtAck   (evtAck),
    .bufRdStb (bufRdStb),
    .bufWrStb (bufWrStb),
    .wcolClr  (wcolClr),
    .relStb   (relStb),
    .errTrap  (errTrap)
  );

  i2c_evt_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rxData   (rxData),
    .txData   (txData),
    .zeroLast (zeroLast)
  );

  a_r10_hold_while_zero: assert property (@(posedge clk) disable iff (!rstN)
    stb.zeroStep |-> !relStb);

endmodule

// File: tb/i2c_evt_ctrl_tb.sv
module i2c_evt_ctrl_tb;

  localparam logic [7:0] P_WADDR = 8'h09;
  localparam logic [7:0] P_WDATA = 8'h29;
  localparam logic [7:0] P_RADDR = 8'h0C;
  localparam logic [7:0] P_RDATA = 8'h2C;
  localparam logic [7:0] P_NACK  = 8'h28;
  localparam logic [7:0] NOISE   = 8'hD2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evtFlag = 1'b0;
  logic [7:0] status = 8'h00;
  logic [7:0] rxData = 8'h00;
  logic       wcol = 1'b0;
  logic       evtAck, bufRdStb, bufWrStb, wcolClr, relStb, errTrap;
  logic [7:0] txData, addrOut;

  int checks = 0, fails = 0;
  int ackCnt = 0, rdCnt = 0, wrCnt = 0, clrCnt = 0, relCnt = 0;
  int collideReq = 0, collUsed = 0;
  logic       finished = 1'b0;
  logic [7:0] expQ [$];
  logic [7:0] model [32];
  int         mIdx = 0;

  always #5 clk = ~clk;

  i2c_evt_ctrl u_dut (
    .clk(clk), .rstN(rstN), .evtFlag(evtFlag), .evtAck(evtAck),
    .status(status), .rxData(rxData), .bufRdStb(bufRdStb), .txData(txData),
    .bufWrStb(bufWrStb), .wcol(wcol), .wcolClr(wcolClr), .relStb(relStb),
    .errTrap(errTrap), .addrOut(addrOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Port model and scoreboard monitor
  always @(negedge clk) begin
    if (evtAck)   ackCnt++;
    if (bufRdStb) rdCnt++;
    if (wcolClr) begin clrCnt++; wcol = 1'b0; end
    if (bufWrStb) begin
      wrCnt++;
      if (collUsed < collideReq) begin wcol = 1'b1; collUsed++; end
    end
    if (relStb) begin
      relCnt++;
      if (expQ.size() == 0) check(1'b0, "R4/R5 unexpected send", txData, 0);
      else begin
        logic [7:0] e;
        e = expQ.pop_front();
        check(txData == e, "R4/R5 sent byte", txData, e);
      end
    end
  end

  task automatic serve(input logic [7:0] st);
    int a0;
    a0 = ackCnt;
    @(negedge clk);
    status  = st;
    evtFlag = 1'b1;
    wait (ackCnt == a0 + 1);
    @(negedge clk);
    evtFlag = 1'b0;
    @(negedge clk);
  endtask

  task automatic modelClear();
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    mIdx = 0;
  endtask

  task automatic doClear();
    int r0, l0;
    r0 = rdCnt; l0 = relCnt;
    serve(P_WADDR);
    modelClear();
    check(rdCnt == r0 + 1, "R2 one dummy read", rdCnt - r0, 1);
    check(relCnt == l0, "R10 no release while zeroing", relCnt - l0, 0);
  endtask

  task automatic doWrite(input logic [7:0] b, input logic [7:0] st);
    int r0;
    r0 = rdCnt;
    rxData = b;
    serve(st);
    model[mIdx] = b;
    mIdx++;
    if (mIdx == 32) mIdx = 0;
    check(rdCnt == r0 + 1, "R3 read strobe per byte", rdCnt - r0, 1);
  endtask

  task automatic doRead(input bit first, input logic [7:0] st);
    int l0;
    l0 = relCnt;
    if (first) mIdx = 0;
    else if (mIdx == 32) mIdx = 0;
    expQ.push_back(model[mIdx]);
    mIdx++;
    serve(st);
    check(relCnt == l0 + 1, "R8 one release per send", relCnt - l0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0, r0, w0, c0, l0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check({evtAck, bufRdStb, bufWrStb, wcolClr, relStb, errTrap} == 6'b0,
          "R11 outputs idle", {evtAck, bufRdStb, bufWrStb, wcolClr, relStb, errTrap}, 0);
    check(addrOut == 8'h02, "R11 slave address", addrOut, 8'h02);

    // R2, R3, R4, R5 basic write then read back, R1 with noise bits
    doClear();
    doWrite(8'hA1, P_WDATA);
    doWrite(8'hB2, P_WDATA | NOISE);
    doWrite(8'hC3, P_WDATA);
    doRead(1'b1, P_RADDR | NOISE);
    doRead(1'b0, P_RDATA);
    doRead(1'b0, P_RDATA | NOISE);
    doRead(1'b0, P_RDATA);

    // R6 master NACK
    r0 = rdCnt; w0 = wrCnt; c0 = clrCnt; l0 = relCnt; a0 = ackCnt;
    serve(P_NACK);
    check(rdCnt == r0 && wrCnt == w0 && clrCnt == c0 && relCnt == l0,
          "R6 no strobes on nack", (rdCnt - r0) + (wrCnt - w0) + (relCnt - l0), 0);
    check(ackCnt == a0 + 1, "R6 nack acknowledged", ackCnt - a0, 1);

    // R2 clear after data, then R3 wrap on 33rd byte, R5 wrap on read
    doClear();
    for (int k = 0; k < 33; k++) doWrite(8'h40 + 8'(k), P_WDATA);
    doRead(1'b1, P_RADDR);
    for (int k = 0; k < 31; k++) doRead(1'b0, P_RDATA);
    doRead(1'b0, P_RDATA);

    // R8 buffer-full wait during send
    w0 = wrCnt;
    a0 = ackCnt;
    if (mIdx == 32) mIdx = 0;
    expQ.push_back(model[mIdx]);
    mIdx++;
    @(negedge clk);
    status = P_RDATA; evtFlag = 1'b1;
    @(negedge clk);
    status = P_RDATA | 8'h01;
    repeat (8) @(negedge clk);
    check(wrCnt == w0, "R8 no write while full", wrCnt - w0, 0);
    status = P_RDATA;
    wait (ackCnt == a0 + 1);
    @(negedge clk); evtFlag = 1'b0; @(negedge clk);
    check(wrCnt == w0 + 1, "R8 write after drain", wrCnt - w0, 1);

    // R8 collision retries
    w0 = wrCnt; c0 = clrCnt;
    collideReq = collideReq + 2;
    doRead(1'b0, P_RDATA);
    check(wrCnt == w0 + 3, "R8 write retried", wrCnt - w0, 3);
    check(clrCnt == c0 + 3, "R8 collision cleared each try", clrCnt - c0, 3);

    // R9 edges while busy ignored, R10 no release during zeroing
    a0 = ackCnt; r0 = rdCnt; l0 = relCnt;
    @(negedge clk);
    status = P_WADDR; evtFlag = 1'b1;
    repeat (4) @(negedge clk);
    evtFlag = 1'b0;
    @(negedge clk);
    status = P_WDATA; rxData = 8'hEE; evtFlag = 1'b1;
    wait (ackCnt == a0 + 1);
    repeat (6) @(negedge clk);
    check(ackCnt == a0 + 1, "R9 single ack", ackCnt - a0, 1);
    check(rdCnt == r0 + 1, "R9 busy edge dropped", rdCnt - r0, 1);
    check(relCnt == l0, "R10 held during zeroing", relCnt - l0, 0);
    evtFlag = 1'b0;
    @(negedge clk);
    modelClear();
    doRead(1'b1, P_RADDR);

    // R7 illegal pattern traps
    a0 = ackCnt; r0 = rdCnt;
    @(negedge clk);
    status = 8'h0D; evtFlag = 1'b1;
    repeat (10) @(negedge clk);
    check(errTrap == 1'b1, "R7 trap raised", errTrap, 1);
    check(ackCnt == a0, "R7 trap not acknowledged", ackCnt - a0, 0);
    evtFlag = 1'b0;
    repeat (2) @(negedge clk);
    status = P_WDATA; evtFlag = 1'b1;
    repeat (10) @(negedge clk);
    check(ackCnt == a0 && rdCnt == r0, "R7 no service after trap", ackCnt - a0, 0);
    check(errTrap == 1'b1, "R7 trap sticky", errTrap, 1);
    evtFlag = 1'b0;

    // R11 reset clears trap
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(errTrap == 1'b0, "R11 trap cleared by reset", errTrap, 0);
    a0 = ackCnt;
    serve(P_NACK);
    check(ackCnt == a0 + 1, "R11 service resumes", ackCnt - a0, 1);
    check(expQ.size() == 0, "R5 all sends observed", expQ.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule